// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the target-side engine that lets a bus host find out which device raised the shared alert line. It runs from a local system clock that oversamples the open-drain SCL and SDA wires. When the local status logic reports an active alert and the host reads from the special alert response address 0x0C, the engine acknowledges. It then returns a single byte that carries its own 7-bit device address in bits 7..1, with bit 0 driven as 1. If the host wants a packet error code, the engine also sends a CRC-8 byte over the address byte and the data byte.

Several devices may answer the same query at once. Each engine drives SDA low only for zero bits. When it releases the line to send a one but then sees the line low at the SCL rising edge, it stops driving at once, so the device with the numerically lowest address completes its transfer. The winner raises a one-cycle `delivered_o` pulse in the acknowledge slot that ends its transfer. Local status logic uses this pulse to drop its alert. A loser keeps its alert, so the host sees the alert line still low and queries again. The engine has no data stream, so its pins are plain control and status signals with no valid/ready handshake.

Top module: `ara_responder`

## Requirements
- R1: After reset the engine does not pull SDA low and `delivered_o` is 0.
- R2: With `alert_active_i` high, a host read from address 0x0C (address byte 0x19) is acknowledged: SDA is held low through the ninth SCL clock.
- R3: With `alert_active_i` low, the 0x0C read is not acknowledged and SDA is never pulled for the whole transfer.
- R4: Any other address byte, including a write to 0x0C (byte 0x18) and a read from 0x0D (byte 0x1B), is not acknowledged and SDA is never pulled.
- R5: After the acknowledge, the engine sends {dev_addr_i, 1'b1} MSB first and changes SDA only while SCL is low.
- R6: Without PEC, `delivered_o` pulses high for exactly one clock during the acknowledge slot after the data byte, and SDA is released.
- R7: With `pec_en_i` high and the host acknowledging the data byte, the next byte is CRC-8 (polynomial 0x07, initial 0, MSB first) over 0x19 and the data byte. No pulse comes after the data byte. The pulse comes in the slot after the CRC byte.
- R8: If the engine sends a one and sees SDA low at an SCL rising edge, it stops driving at once and gives no `delivered_o` pulse for that query.
- R9: Against a rival that answers with a higher address, the engine wins, and its byte and pulse are delivered intact.
- R10: A STOP seen before the data byte has been fully sent returns the engine to idle with no pulse, and SDA is released.
- R11: With PEC enabled, a host NACK after the data byte ends the transfer and produces the pulse.
- R12: A repeated START in the middle of an address byte restarts address decoding, and a following 0x0C read is answered normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| alert_active_i | input | 1 | Local alert is pending |
| dev_addr_i | input | ADDR_W | Own 7-bit device address |
| pec_en_i | input | 1 | Host uses receive byte with PEC |
| delivered_o | output | 1 | One-cycle pulse: address delivered, release alert |

## Verification
The bench builds the engine with its default parameters: a two-stage input synchronizer, a 7-bit address, special address 0x0C and polynomial 0x07. With two stages, every SCL phase of eight clocks is seen with margin, so the acknowledge, drive and sample points fall at fixed places inside each phase. The 7-bit address space lets the bench pick an all-ones address, which never pulls SDA and so leaves room for a mid-byte STOP. It also allows address pairs that first differ at the MSB or at a middle bit. A rival device modelled on the shared wire then exercises both losing and winning arbitration.

// File: rtl/ara_pkg.sv
package ara_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_SET,
    ST_ACK_HOLD,
    ST_ACK_END,
    ST_TX,
    ST_TX_REL,
    ST_TX_ACK,
    ST_PEC_LOAD
  } ara_state_e;

  // One byte of CRC-8 update, MSB first.
  function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in,
                                           input logic [7:0] data,
                                           input logic [7:0] poly);
    logic [7:0] c;
    c = crc_in ^ data;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ poly) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/ara_line_sync.sv
module ara_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= {STAGES{1'b1}};
      sda_q <= {STAGES{1'b1}};
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s    = scl_q[STAGES-1];
  assign sda_s    = sda_q[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  // SDA edges while SCL stays high mark bus conditions
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/ara_rx_shift.sv
module ara_rx_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] next_byte,
  output logic         done
);
  localparam int CW = $clog2(W + 1);

  logic [W-2:0] byte_q;
  logic [CW-1:0] cnt;

  assign next_byte = {byte_q, bit_in};
  assign done      = shift_en && (cnt == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      cnt    <= '0;
    end else if (clear) begin
      byte_q <= '0;
      cnt    <= '0;
    end else if (shift_en) begin
      byte_q <= next_byte[W-2:0];
      cnt    <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ara_crc8.sv
module ara_crc8 #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic [7:0] first_i,
  input  logic [7:0] second_i,
  output logic [7:0] crc_o
);
  import ara_pkg::*;

  assign crc_o = crc8_byte(crc8_byte(8'h00, first_i, POLY), second_i, POLY);

endmodule

// File: rtl/ara_responder.sv
module ara_responder #(
  parameter int          ADDR_W      = 7,
  parameter logic [6:0]  ARA_ADDR    = 7'h0C,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  CRC_POLY    = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic              alert_active_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              pec_en_i,
  output logic              delivered_o
);
  import ara_pkg::*;

  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [BYTE_W-1:0] ARA_READ = {ARA_ADDR, 1'b1};

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  ara_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  ara_state_e        state;
  logic [BYTE_W-1:0] rx_next;
  logic              rx_done, rx_shift;

  assign rx_shift = (state == ST_ADDR) && scl_rise;

  ara_rx_shift #(.W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clear(start_ev), .shift_en(rx_shift),
    .bit_in(sda_s), .next_byte(rx_next), .done(rx_done)
  );

  logic [BYTE_W-1:0] data_byte, tx_byte;
  logic [7:0]        crc_val;

  ara_crc8 #(.POLY(CRC_POLY)) u_crc (
    .first_i(ARA_READ), .second_i(data_byte), .crc_o(crc_val)
  );

  logic [CNT_W-1:0] tx_cnt;
  logic             sda_pull, delivered, in_pec, pec_sel, pending;
  logic             arb_lost;

  // released for a one but the wire reads low
  assign arb_lost = (state == ST_TX) && scl_rise && !sda_pull && !sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      data_byte <= '0;
      tx_byte   <= '0;
      tx_cnt    <= '0;
      sda_pull  <= 1'b0;
      delivered <= 1'b0;
      in_pec    <= 1'b0;
      pec_sel   <= 1'b0;
      pending   <= 1'b0;
    end else begin
      delivered <= 1'b0;
      if (start_ev || stop_ev) begin
        delivered <= pending;
        pending   <= 1'b0;
        sda_pull  <= 1'b0;
        in_pec    <= 1'b0;
        state     <= start_ev ? ST_ADDR : ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (rx_done) begin
              if ((rx_next == ARA_READ) && alert_active_i) begin
                data_byte <= {dev_addr_i, 1'b1};
                pec_sel   <= pec_en_i;
                state     <= ST_ACK_SET;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ACK_SET: begin
            if (scl_fall) begin
              sda_pull <= 1'b1;
              state    <= ST_ACK_HOLD;
            end
          end
          ST_ACK_HOLD: begin
            if (scl_rise) state <= ST_ACK_END;
          end
          ST_ACK_END: begin
            if (scl_fall) begin
              tx_byte  <= data_byte;
              sda_pull <= ~data_byte[BYTE_W-1];
              tx_cnt   <= '0;
              in_pec   <= 1'b0;
              state    <= ST_TX;
            end
          end
          ST_TX: begin
            if (arb_lost) begin
              sda_pull <= 1'b0;
              state    <= ST_IDLE;
            end else if (scl_rise) begin
              if (tx_cnt == CNT_W'(BYTE_W - 1)) begin
                if (!in_pec) pending <= 1'b1;
                state <= ST_TX_REL;
              end else begin
                tx_cnt <= tx_cnt + 1'b1;
              end
            end else if (scl_fall) begin
              tx_byte  <= tx_byte << 1;
              sda_pull <= ~tx_byte[BYTE_W-2];
            end
          end
          ST_TX_REL: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              state    <= ST_TX_ACK;
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              if (!in_pec && pec_sel && !sda_s) begin
                state <= ST_PEC_LOAD;
              end else begin
                delivered <= 1'b1;
                pending   <= 1'b0;
                state     <= ST_IDLE;
              end
            end
          end
          ST_PEC_LOAD: begin
            if (scl_fall) begin
              tx_byte  <= crc_val;
              sda_pull <= ~crc_val[7];
              tx_cnt   <= '0;
              in_pec   <= 1'b1;
              state    <= ST_TX;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_pull_o  = sda_pull;
  assign delivered_o = delivered;

  // R5: the pull enable only moves while the sampled clock is low
  p_pull_moves_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !scl_s);

  // R6: release pulse lasts one clock
  p_deliver_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    delivered_o |=> !delivered_o);

  // R8: losing arbitration drops the drive and returns to idle
  p_lost_lets_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> (state == ST_IDLE) && !sda_pull_o);

  // R10: STOP always idles with SDA released
  p_stop_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE) && !sda_pull_o);

  // R3: acknowledge is entered only with the alert active
  p_ack_needs_alert_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK_SET && $past(state) == ST_ADDR) |-> $past(alert_active_i));

endmodule

// File: tb/test_ara_responder.sv
module test_ara_responder;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_h = 1'b1, sda_h = 1'b1, rival_pull = 1'b0;
  logic       alert = 1'b0, pec_en = 1'b0;
  logic [6:0] dev_addr = 7'h00;
  logic       sda_pull, delivered;
  logic       sda_line;

  int  n_tests = 0, n_fail = 0, deliv_cnt = 0, pull_cycles = 0;
  bit  done = 0;

  assign sda_line = sda_h & ~sda_pull & ~rival_pull;

  ara_responder i_ara_responder (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .alert_active_i(alert), .dev_addr_i(dev_addr),
    .pec_en_i(pec_en), .delivered_o(delivered)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (delivered) deliv_cnt++;
    if (sda_pull) pull_cycles++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_ref(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] s;
    logic [7:0]  c;
    logic        fb;
    s = {a, b};
    c = 8'h00;
    for (int i = 15; i >= 0; i--) begin
      fb = c[7] ^ s[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic bus_start();
    sda_h = 1'b1; scl_h = 1'b1; tick(HALF);
    sda_h = 1'b0; tick(HALF);
    scl_h = 1'b0; tick(2);
  endtask

  task automatic bus_restart();
    tick(2); sda_h = 1'b1; tick(HALF);
    scl_h = 1'b1; tick(HALF);
    sda_h = 1'b0; tick(HALF);
    scl_h = 1'b0; tick(2);
  endtask

  task automatic bus_stop();
    tick(2); sda_h = 1'b0; tick(HALF);
    scl_h = 1'b1; tick(HALF);
    sda_h = 1'b1; tick(HALF);
  endtask

  task automatic write_bit(input logic b);
    tick(2); sda_h = b; tick(HALF - 2);
    scl_h = 1'b1; tick(HALF);
    scl_h = 1'b0;
  endtask

  task automatic read_bit(input logic rdrive, output logic v);
    tick(2); sda_h = 1'b1; rival_pull = rdrive; tick(HALF - 2);
    scl_h = 1'b1; tick(HALF - 2);
    v = sda_line; tick(2);
    scl_h = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic v;
    for (int i = 7; i >= 0; i--) write_bit(b[i]);
    read_bit(1'b0, v);
    acked = !v;
  endtask

  task automatic read_byte(input logic rival_on_in, input logic [7:0] rival_byte,
                           output logic [7:0] b);
    logic v;
    logic live;
    live = rival_on_in;
    for (int i = 7; i >= 0; i--) begin
      read_bit(live & ~rival_byte[i], v);
      if (live && rival_byte[i] && !v) live = 1'b0;
      b[i] = v;
    end
    rival_pull = 1'b0;
  endtask

  task automatic t_reset();
    check_eq("R1 sda_pull after reset", sda_pull, 0);
    check_eq("R1 delivered after reset", delivered, 0);
  endtask

  task automatic t_plain();
    logic ack; logic [7:0] b; int d0;
    dev_addr = 7'h2A; alert = 1; pec_en = 0; d0 = deliv_cnt;
    bus_start(); send_byte(8'h19, ack);
    check_eq("R2 ack of 0x0C read", ack, 1);
    read_byte(1'b0, 8'h00, b);
    check_eq("R5 data byte", b, 8'h55);
    write_bit(1'b1);
    tick(2);
    check_eq("R6 one delivered pulse", deliv_cnt - d0, 1);
    check_eq("R6 sda released", sda_pull, 0);
    bus_stop();
  endtask

  task automatic t_no_alert();
    logic ack;
    alert = 0; dev_addr = 7'h2A; pull_cycles = 0;
    bus_start(); send_byte(8'h19, ack);
    check_eq("R3 no ack without alert", ack, 0);
    bus_stop();
    check_eq("R3 no pull cycles", pull_cycles, 0);
  endtask

  task automatic t_other_addr();
    logic ack;
    alert = 1; pull_cycles = 0;
    bus_start(); send_byte(8'h1B, ack);
    check_eq("R4 no ack for 0x0D read", ack, 0);
    bus_stop();
    bus_start(); send_byte(8'h18, ack);
    check_eq("R4 no ack for 0x0C write", ack, 0);
    bus_stop();
    check_eq("R4 no pull cycles", pull_cycles, 0);
  endtask

  task automatic t_pec();
    logic ack; logic [7:0] b; int d0;
    dev_addr = 7'h13; alert = 1; pec_en = 1; d0 = deliv_cnt;
    bus_start(); send_byte(8'h19, ack);
    check_eq("R7 ack with pec", ack, 1);
    read_byte(1'b0, 8'h00, b);
    check_eq("R7 data byte with pec", b, 8'h27);
    write_bit(1'b0);
    tick(2);
    check_eq("R7 no pulse after data ack", deliv_cnt - d0, 0);
    read_byte(1'b0, 8'h00, b);
    check_eq("R7 crc byte", b, crc_ref(8'h19, 8'h27));
    write_bit(1'b1);
    tick(2);
    check_eq("R7 pulse after crc", deliv_cnt - d0, 1);
    bus_stop();
    pec_en = 0;
  endtask

  task automatic t_pec_nack();
    logic ack; logic [7:0] b; int d0;
    dev_addr = 7'h3C; alert = 1; pec_en = 1; d0 = deliv_cnt;
    bus_start(); send_byte(8'h19, ack);
    read_byte(1'b0, 8'h00, b);
    check_eq("R11 data byte", b, 8'h79);
    write_bit(1'b1);
    tick(2);
    check_eq("R11 pulse on data nack", deliv_cnt - d0, 1);
    bus_stop();
    pec_en = 0;
  endtask

  task automatic t_lose();
    logic ack; logic [7:0] b; int d0;
    dev_addr = 7'h40; alert = 1; d0 = deliv_cnt;
    bus_start(); send_byte(8'h19, ack);
    read_byte(1'b1, {7'h21, 1'b1}, b);
    check_eq("R8 wire shows rival byte", b, 8'h43);
    check_eq("R8 engine released", sda_pull, 0);
    write_bit(1'b1);
    bus_stop();
    check_eq("R8 no pulse after loss", deliv_cnt - d0, 0);
  endtask

  task automatic t_win();
    logic ack; logic [7:0] b; int d0;
    dev_addr = 7'h05; alert = 1; d0 = deliv_cnt;
    bus_start(); send_byte(8'h19, ack);
    read_byte(1'b1, {7'h30, 1'b1}, b);
    check_eq("R9 winner byte intact", b, 8'h0B);
    write_bit(1'b1);
    tick(2);
    check_eq("R9 winner pulse", deliv_cnt - d0, 1);
    bus_stop();
  endtask

  task automatic t_stop_mid();
    logic ack, v; int d0;
    dev_addr = 7'h7F; alert = 1; d0 = deliv_cnt;
    bus_start(); send_byte(8'h19, ack);
    check_eq("R10 ack before stop", ack, 1);
    for (int i = 0; i < 4; i++) read_bit(1'b0, v);
    bus_stop();
    tick(4);
    check_eq("R10 no pulse on early stop", deliv_cnt - d0, 0);
    check_eq("R10 sda released", sda_pull, 0);
  endtask

  task automatic t_restart();
    logic ack; logic [7:0] b; int d0;
    dev_addr = 7'h2A; alert = 1; d0 = deliv_cnt;
    bus_start();
    write_bit(1'b0); write_bit(1'b0); write_bit(1'b0);
    bus_restart();
    send_byte(8'h19, ack);
    check_eq("R12 ack after restart", ack, 1);
    read_byte(1'b0, 8'h00, b);
    check_eq("R12 byte after restart", b, 8'h55);
    write_bit(1'b1);
    tick(2);
    check_eq("R12 pulse after restart", deliv_cnt - d0, 1);
    bus_stop();
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_plain();
    t_no_alert();
    t_other_addr();
    t_pec();
    t_pec_nack();
    t_lose();
    t_win();
    t_stop_mid();
    t_restart();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule